// File: doc/BRIEF.md
# MDIO management bus master

This block runs complete management frames on a two-wire MDIO bus on behalf of a single host. The host presents a request with a valid/ready handshake. The request selects read or write and the short (Clause 22) or extended (Clause 45) frame format. It also carries a 5-bit PHY address, a 5-bit register or device field, a 16-bit extended register address and 16-bit write data. The master generates MDC from a parameterized divider. It drives MDIO through an output and an output-enable, and samples the returned MDIO input.

An extended-format request becomes two back-to-back frames. An address frame that carries the 16-bit register address comes first. The read or write frame follows, with the same PHY and device fields. On a read, the master checks the turnaround bit the PHY returns. A per-PHY mask can excuse PHYs whose turnaround is known to be bad. A bad turnaround that is not excused makes the master clock out 32 further bits. It then reports all ones and raises an error flag. Each completed request ends with a one-cycle done pulse. The read data and error flag then stay unchanged until the next request is accepted.

Top module: `mdio_master`

## Requirements
- R1: Every frame starts with 32 one bits driven by the master, with `mdio_oe_o` high.
- R2: A short-format frame sends start bits 01, then an opcode. When `c22_op_sel_i` is 0 the opcode is 10 for a read and 01 for a write. When it is 1 the opcode is `c22_rd_op_i` or `c22_wr_op_i`.
- R3: An extended request sends an address frame first, with start 00 and opcode 00, carrying `req_ext_addr_i`. The second frame uses start 00 and opcode 11 for a read or 01 for a write. The opcode override does not apply to extended frames.
- R4: After the opcode, the PHY address and then the register or device field follow, 5 bits each, most significant bit first.
- R5: A write frame or an address frame drives turnaround bits 1 then 0 and then 16 data bits, MSB first. The master then releases MDIO and clocks one extra input bit.
- R6: A read frame releases MDIO after the register field and samples one turnaround bit. If the turnaround bit is 0, the master clocks in 16 data bits MSB first and one trailing bit, and returns the data with `rsp_ta_err_o` = 0.
- R7: If a read turnaround bit is 1 and mask bit `ta_ignore_i[phy]` is 0, the master clocks 32 more input bits, returns 16'hFFFF and sets `rsp_ta_err_o` = 1.
- R8: If `ta_ignore_i[phy]` is 1, a turnaround bit of 1 is treated as good and the read proceeds as in R6.
- R9: Every bit holds MDC low for `HALF_CYC` clocks and then high. The high phase lasts `HALF_CYC` clocks for a driven bit and `RD_HIGH_CYC` clocks for an input bit. MDIO input is sampled at the clock edge where MDC falls.
- R10: While idle, `req_ready_o` is 1 and both MDC and `mdio_oe_o` are 0.
- R11: A request is accepted only when `req_valid_i` and `req_ready_o` are both 1. `req_valid_i` has no effect while a request is in progress.
- R12: `rsp_done_o` is a single-cycle pulse per request. Read data and the error flag are updated with that pulse and then held. A write clears the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Master idle, can accept a request |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_ext_i | input | 1 | 1 = extended (two-frame) format |
| req_phy_i | input | 5 | PHY address |
| req_reg_i | input | 5 | Register (short) or device (extended) field |
| req_ext_addr_i | input | 16 | Extended register address |
| req_wdata_i | input | 16 | Write data |
| c22_op_sel_i | input | 1 | Use the short-format opcode overrides |
| c22_rd_op_i | input | 2 | Short-format read opcode override |
| c22_wr_op_i | input | 2 | Short-format write opcode override |
| ta_ignore_i | input | 32 | Per-PHY mask excusing a bad read turnaround |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |
| rsp_done_o | output | 1 | Request complete pulse |
| rsp_rdata_o | output | 16 | Read data |
| rsp_ta_err_o | output | 1 | Turnaround error flag |

## Verification
The table drives short writes and reads, and extended writes and reads. Comparing the full captured output bit stream separates start and opcode encodings, field order and the single versus two-frame sequences. Reads are tried with a good turnaround, a bad turnaround on an unmasked PHY, and a bad turnaround on a masked PHY. The count of input clocks and the returned data then tell the data, flush and excused paths apart. Separate runs with the opcode override prove that it changes short frames only. A request raised mid-transfer with different fields shows that a busy master ignores it. MDC phase widths are measured on every bit, so a driven-bit high phase is told apart from an input-bit high phase.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_HDR,
    ST_WDAT,
    ST_RTA,
    ST_RDAT,
    ST_TRAIL,
    ST_FLUSH
  } mdio_st_e;

  localparam logic [1:0] START_SHORT  = 2'b01;
  localparam logic [1:0] START_EXT    = 2'b00;
  localparam logic [1:0] OP_SHORT_RD  = 2'b10;
  localparam logic [1:0] OP_SHORT_WR  = 2'b01;
  localparam logic [1:0] OP_EXT_ADDR  = 2'b00;
  localparam logic [1:0] OP_EXT_RD    = 2'b11;
  localparam logic [1:0] OP_EXT_WR    = 2'b01;
  localparam logic [1:0] TA_DRIVE     = 2'b10;

endpackage

// File: rtl/mdio_bit_timer.sv
module mdio_bit_timer #(
  parameter int HALF_CYC    = 13,
  parameter int RD_HIGH_CYC = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic in_bit_i,
  output logic mdc_o,
  output logic bit_done_o
);

  localparam int MAXC = (HALF_CYC > RD_HIGH_CYC) ? HALF_CYC : RD_HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          hi;

  assign mdc_o      = hi;
  assign bit_done_o = run_i && hi && (cnt == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= CW'(HALF_CYC - 1);
      hi  <= 1'b0;
    end else if (!run_i) begin
      cnt <= CW'(HALF_CYC - 1);
      hi  <= 1'b0;
    end else if (cnt == '0) begin
      hi  <= !hi;
      // input bits keep MDC high longer to cover PHY output delay
      cnt <= hi ? CW'(HALF_CYC - 1)
                : (in_bit_i ? CW'(RD_HIGH_CYC - 1) : CW'(HALF_CYC - 1));
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

  // R9: each falling edge opens a full low phase
  assert_fall_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mdc_o) |-> (!run_i || cnt == CW'(HALF_CYC - 1)));

  // R9: MDC only rises while a frame runs
  assert_rise_run_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_o) |-> $past(run_i));

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
#(
  parameter int PHY_AW    = 5,
  parameter int REG_AW    = 5,
  parameter int DATA_W    = 16,
  parameter int PRE_LEN   = 32,
  parameter int FLUSH_LEN = 32,
  localparam int NPHY     = 1 << PHY_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_rd_i,
  input  logic              req_ext_i,
  input  logic [PHY_AW-1:0] req_phy_i,
  input  logic [REG_AW-1:0] req_reg_i,
  input  logic [DATA_W-1:0] req_ext_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              c22_op_sel_i,
  input  logic [1:0]        c22_rd_op_i,
  input  logic [1:0]        c22_wr_op_i,
  input  logic [NPHY-1:0]   ta_ignore_i,
  input  logic              bit_done_i,
  output logic              run_o,
  output logic              in_bit_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i,
  output logic              rsp_done_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              rsp_ta_err_o
);

  localparam int HDR_W   = 4 + PHY_AW + REG_AW;
  localparam int WD_W    = DATA_W + 2;
  localparam int SR_A    = (PRE_LEN > WD_W) ? PRE_LEN : WD_W;
  localparam int SR_W    = (SR_A > HDR_W) ? SR_A : HDR_W;
  localparam int MAX_LEN = (SR_W > FLUSH_LEN) ? SR_W : FLUSH_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  mdio_st_e          st;
  logic              first_q, rd_q, ext_q;
  logic [PHY_AW-1:0] phy_q;
  logic [REG_AW-1:0] reg_q;
  logic [DATA_W-1:0] addr_q, wdat_q, rsr, rdata_q;
  logic [SR_W-1:0]   sr, sr_hdr, sr_wd;
  logic [CNT_W-1:0]  bcnt, seg_len;
  logic              done_q, err_q, frame_rd, seg_last;
  logic [1:0]        start_bits, op_bits;

  assign frame_rd = rd_q && !(ext_q && first_q);

  always_comb begin
    if (!ext_q) begin
      start_bits = START_SHORT;
      if (rd_q) op_bits = c22_op_sel_i ? c22_rd_op_i : OP_SHORT_RD;
      else      op_bits = c22_op_sel_i ? c22_wr_op_i : OP_SHORT_WR;
    end else begin
      start_bits = START_EXT;
      op_bits    = first_q ? OP_EXT_ADDR : (rd_q ? OP_EXT_RD : OP_EXT_WR);
    end
  end

  assign sr_hdr = SR_W'({start_bits, op_bits, phy_q, reg_q}) << (SR_W - HDR_W);
  assign sr_wd  = SR_W'({TA_DRIVE, (ext_q && first_q) ? addr_q : wdat_q}) << (SR_W - WD_W);

  always_comb begin
    unique case (st)
      ST_PRE:   seg_len = CNT_W'(PRE_LEN);
      ST_HDR:   seg_len = CNT_W'(HDR_W);
      ST_WDAT:  seg_len = CNT_W'(WD_W);
      ST_RDAT:  seg_len = CNT_W'(DATA_W);
      ST_FLUSH: seg_len = CNT_W'(FLUSH_LEN);
      default:  seg_len = CNT_W'(1);
    endcase
  end

  assign seg_last    = (bcnt == seg_len - 1'b1);
  assign mdio_oe_o   = (st == ST_PRE) || (st == ST_HDR) || (st == ST_WDAT);
  assign mdio_o      = mdio_oe_o && sr[SR_W-1];
  assign run_o       = (st != ST_IDLE);
  assign in_bit_o    = run_o && !mdio_oe_o;
  assign req_ready_o = (st == ST_IDLE);
  assign rsp_done_o  = done_q;
  assign rsp_rdata_o = rdata_q;
  assign rsp_ta_err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      first_q <= 1'b0;
      rd_q    <= 1'b0;
      ext_q   <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      addr_q  <= '0;
      wdat_q  <= '0;
      sr      <= '0;
      bcnt    <= '0;
      rsr     <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st == ST_IDLE) begin
        if (req_valid_i) begin
          rd_q    <= req_rd_i;
          ext_q   <= req_ext_i;
          first_q <= req_ext_i;
          phy_q   <= req_phy_i;
          reg_q   <= req_reg_i;
          addr_q  <= req_ext_addr_i;
          wdat_q  <= req_wdata_i;
          sr      <= '1;
          bcnt    <= '0;
          st      <= ST_PRE;
        end
      end else if (bit_done_i) begin
        sr   <= sr << 1;
        bcnt <= bcnt + 1'b1;
        if (st == ST_RDAT) rsr <= {rsr[DATA_W-2:0], mdio_i};
        if (seg_last) begin
          bcnt <= '0;
          unique case (st)
            ST_PRE: begin
              st <= ST_HDR;
              sr <= sr_hdr;
            end
            ST_HDR: begin
              if (frame_rd) st <= ST_RTA;
              else begin
                st <= ST_WDAT;
                sr <= sr_wd;
              end
            end
            ST_WDAT: st <= ST_TRAIL;
            ST_RTA:  st <= (mdio_i && !ta_ignore_i[phy_q]) ? ST_FLUSH : ST_RDAT;
            ST_RDAT: st <= ST_TRAIL;
            ST_TRAIL: begin
              if (ext_q && first_q) begin
                first_q <= 1'b0;
                sr      <= '1;
                st      <= ST_PRE;
              end else begin
                st     <= ST_IDLE;
                done_q <= 1'b1;
                err_q  <= 1'b0;
                if (rd_q) rdata_q <= rsr;
              end
            end
            ST_FLUSH: begin
              st      <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '1;
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  // R1: preamble is driven ones
  assert_pre_ones_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PRE) |-> (mdio_oe_o && mdio_o));

  // R11: accepting a request leaves the master busy
  assert_accept_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);

  // R7: an error completion reports all ones
  assert_err_ones_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_done_o && rsp_ta_err_o) |-> (rsp_rdata_o == '1));

  // R12: done is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> !rsp_done_o);

  // R12: response held outside the done pulse
  assert_rsp_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_done_o |-> ($stable(rsp_rdata_o) && $stable(rsp_ta_err_o)));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_CYC    = 13,
  parameter int RD_HIGH_CYC = 18
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_rd_i,
  input  logic        req_ext_i,
  input  logic [4:0]  req_phy_i,
  input  logic [4:0]  req_reg_i,
  input  logic [15:0] req_ext_addr_i,
  input  logic [15:0] req_wdata_i,
  input  logic        c22_op_sel_i,
  input  logic [1:0]  c22_rd_op_i,
  input  logic [1:0]  c22_wr_op_i,
  input  logic [31:0] ta_ignore_i,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i,
  output logic        rsp_done_o,
  output logic [15:0] rsp_rdata_o,
  output logic        rsp_ta_err_o
);

  logic run, in_bit, bit_done;

  mdio_bit_timer #(
    .HALF_CYC   (HALF_CYC),
    .RD_HIGH_CYC(RD_HIGH_CYC)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .in_bit_i  (in_bit),
    .mdc_o     (mdc_o),
    .bit_done_o(bit_done)
  );

  mdio_frame_seq #(
    .PHY_AW   (5),
    .REG_AW   (5),
    .DATA_W   (16),
    .PRE_LEN  (32),
    .FLUSH_LEN(32)
  ) u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_ready_o   (req_ready_o),
    .req_rd_i      (req_rd_i),
    .req_ext_i     (req_ext_i),
    .req_phy_i     (req_phy_i),
    .req_reg_i     (req_reg_i),
    .req_ext_addr_i(req_ext_addr_i),
    .req_wdata_i   (req_wdata_i),
    .c22_op_sel_i  (c22_op_sel_i),
    .c22_rd_op_i   (c22_rd_op_i),
    .c22_wr_op_i   (c22_wr_op_i),
    .ta_ignore_i   (ta_ignore_i),
    .bit_done_i    (bit_done),
    .run_o         (run),
    .in_bit_o      (in_bit),
    .mdio_o        (mdio_o),
    .mdio_oe_o     (mdio_oe_o),
    .mdio_i        (mdio_i),
    .rsp_done_o    (rsp_done_o),
    .rsp_rdata_o   (rsp_rdata_o),
    .rsp_ta_err_o  (rsp_ta_err_o)
  );

  // R10: bus quiet while idle
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mdc_o && !mdio_oe_o));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int RDH  = 4;
  localparam logic [31:0] MASK = 32'h0000_0200;
  localparam logic [1:0] ORD = 2'b00;
  localparam logic [1:0] OWR = 2'b11;

  typedef struct packed {
    logic        rd;
    logic        ext;
    logic        ovr;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] addr;
    logic [15:0] wd;
    logic [15:0] pd;
    logic        ta;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 5'd5,  5'h1A, 16'h0000, 16'hA5C3, 16'h0000, 1'b0},
    '{1'b1, 1'b0, 1'b0, 5'd3,  5'h02, 16'h0000, 16'h0000, 16'h1234, 1'b0},
    '{1'b1, 1'b0, 1'b0, 5'd7,  5'h01, 16'h0000, 16'h0000, 16'hBEEF, 1'b1},
    '{1'b1, 1'b0, 1'b0, 5'd9,  5'h11, 16'h0000, 16'h0000, 16'h0F0F, 1'b1},
    '{1'b0, 1'b1, 1'b0, 5'd31, 5'h01, 16'h8001, 16'h5555, 16'h0000, 1'b0},
    '{1'b1, 1'b1, 1'b0, 5'd0,  5'h03, 16'h0007, 16'h0000, 16'hC0DE, 1'b0},
    '{1'b1, 1'b1, 1'b0, 5'd2,  5'h07, 16'h1111, 16'h0000, 16'h7777, 1'b1},
    '{1'b0, 1'b0, 1'b0, 5'd0,  5'h00, 16'h0000, 16'hFFFF, 16'h0000, 1'b0},
    '{1'b1, 1'b0, 1'b1, 5'd12, 5'h15, 16'h0000, 16'h0000, 16'h8421, 1'b0},
    '{1'b0, 1'b0, 1'b1, 5'd17, 5'h0A, 16'h0000, 16'h3C3C, 16'h0000, 1'b0},
    '{1'b1, 1'b1, 1'b1, 5'd9,  5'h1F, 16'hFFFE, 16'h0000, 16'h0001, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_rd = 1'b0, req_ext = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_addr = '0, req_wdata = '0;
  logic op_sel = 1'b0;
  logic req_ready, mdc, mdio_out, mdio_oe, done, ta_err;
  logic mdio_in = 1'b1;
  logic [15:0] rdata;

  int checks = 0, errors = 0;
  logic [127:0] cap;
  int cap_n = 0, in_n = 0, in_idx = 0;
  logic ta_val = 1'b0;
  logic [15:0] pdata = '0;
  int hi_cnt = 0, lo_cnt = 0, wbad = 0, done_cnt = 0;
  logic last_oe = 1'b0;
  logic [15:0] exp_rdata = '0;
  logic exp_err = 1'b0;
  bit finished = 0;

  mdio_master #(.HALF_CYC(HALF), .RD_HIGH_CYC(RDH)) u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_rd_i(req_rd), .req_ext_i(req_ext),
    .req_phy_i(req_phy), .req_reg_i(req_reg),
    .req_ext_addr_i(req_addr), .req_wdata_i(req_wdata),
    .c22_op_sel_i(op_sel), .c22_rd_op_i(ORD), .c22_wr_op_i(OWR),
    .ta_ignore_i(MASK),
    .mdc_o(mdc), .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in),
    .rsp_done_o(done), .rsp_rdata_o(rdata), .rsp_ta_err_o(ta_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // PHY model: capture driven bits, answer on input bits
  always @(posedge mdc) begin
    if (mdio_oe) begin
      cap    <= {cap[126:0], mdio_out};
      cap_n  <= cap_n + 1;
      in_idx <= 0;
    end else begin
      if (in_idx == 0)       mdio_in <= ta_val;
      else if (in_idx <= 16) mdio_in <= pdata[16-in_idx];
      else                   mdio_in <= 1'b1;
      in_idx <= in_idx + 1;
      in_n   <= in_n + 1;
    end
  end

  // MDC phase width monitor
  always @(negedge clk) begin
    if (rsp_seen_high()) begin end
    if (mdc) begin
      if (lo_cnt != 0 && lo_cnt != HALF) wbad++;
      lo_cnt  = 0;
      hi_cnt++;
      last_oe = mdio_oe;
    end else begin
      if (hi_cnt != 0 && hi_cnt != (last_oe ? HALF : RDH)) wbad++;
      hi_cnt = 0;
      if (!req_ready) lo_cnt++;
    end
    if (done) done_cnt++;
  end

  function automatic bit rsp_seen_high();
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void push(inout logic [127:0] s, inout int n, input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      s = {s[126:0], v[i]};
      n++;
    end
  endfunction

  function automatic void frame(inout logic [127:0] s, inout int n, input logic [1:0] stb,
                                input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                                input bit has, input logic [15:0] d);
    push(s, n, 32'hFFFF_FFFF, 32);
    push(s, n, {30'b0, stb}, 2);
    push(s, n, {30'b0, op}, 2);
    push(s, n, {27'b0, phy}, 5);
    push(s, n, {27'b0, rg}, 5);
    if (has) begin
      push(s, n, 32'h2, 2);
      push(s, n, {16'b0, d}, 16);
    end
  endfunction

  task automatic run_vec(input vec_t v, input bit intrude);
    logic [127:0] es, pre;
    int en, ein, n;
    bit bad;
    logic [15:0] hold_d;
    logic hold_e;
    logic [1:0] op;
    string tag;
    es = '0; en = 0;
    bad = v.rd && v.ta && !MASK[v.phy];
    if (v.ext) frame(es, en, 2'b00, 2'b00, v.phy, v.rg, 1'b1, v.addr);
    if (v.ext)      op = v.rd ? 2'b11 : 2'b01;
    else if (v.rd)  op = v.ovr ? ORD : 2'b10;
    else            op = v.ovr ? OWR : 2'b01;
    frame(es, en, v.ext ? 2'b00 : 2'b01, op, v.phy, v.rg, !v.rd, v.wd);
    ein = (v.ext ? 1 : 0) + (v.rd ? (bad ? 33 : 18) : 1);
    if (v.rd) begin
      exp_rdata = bad ? 16'hFFFF : v.pd;
      exp_err   = bad;
    end else exp_err = 1'b0;
    tag = v.ext ? "R3 R4 R5" : (v.ovr ? "R2 R4 R5" : "R2 R4 R5");

    cap = '0; cap_n = 0; in_n = 0; wbad = 0; hi_cnt = 0; lo_cnt = 0; done_cnt = 0;
    ta_val = v.ta; pdata = v.pd;
    @(negedge clk);
    op_sel = v.ovr; req_rd = v.rd; req_ext = v.ext; req_phy = v.phy; req_reg = v.rg;
    req_addr = v.addr; req_wdata = v.wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 20000) begin
      @(negedge clk);
      n++;
      if (intrude && n == 100) begin
        req_rd = !v.rd; req_phy = ~v.phy; req_reg = ~v.rg; req_wdata = ~v.wd; req_valid = 1'b1;
      end
      if (intrude && n == 150) req_valid = 1'b0;
    end
    chk(done, "R12 done seen", 128'(done), 128'd1);
    chk(cap == es && cap_n == en, tag, cap, es);
    pre = cap >> (cap_n - 32);
    chk(pre[31:0] == 32'hFFFF_FFFF, "R1 preamble", pre, 128'hFFFF_FFFF);
    chk(in_n == ein, v.rd ? (bad ? "R7 flush clocks" : "R6 R8 input clocks") : "R5 trailing clock",
        128'(in_n), 128'(ein));
    chk(rdata == exp_rdata, bad ? "R7 rdata" : (v.ta ? "R8 rdata" : "R6 rdata"), 128'(rdata), 128'(exp_rdata));
    chk(ta_err == exp_err, v.rd ? "R7 R8 err flag" : "R12 write clears err", 128'(ta_err), 128'(exp_err));
    chk(wbad == 0, "R9 MDC phase widths", 128'(wbad), 128'd0);
    hold_d = rdata; hold_e = ta_err;
    @(negedge clk);
    chk(!done && done_cnt == 1, "R12 single done pulse", 128'(done_cnt), 128'd1);
    if (intrude) chk(cap_n == en, "R11 busy request ignored", 128'(cap_n), 128'(en));
    repeat (20) @(negedge clk);
    chk(rdata == hold_d && ta_err == hold_e, "R12 response held", 128'(rdata), 128'(hold_d));
    chk(req_ready && !mdc && !mdio_oe && cap_n == en, "R10 R11 idle quiet",
        128'({req_ready, mdc, mdio_oe}), 128'b100);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk(req_ready && !mdc && !mdio_oe && !done && rdata == 16'h0 && !ta_err, "R10 reset state",
        128'({req_ready, mdc, mdio_oe, done, ta_err}), 128'b10000);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(req_ready && !mdc && !mdio_oe, "R10 idle after reset", 128'({req_ready, mdc, mdio_oe}), 128'b100);
    for (int i = 0; i < NV; i++) run_vec(VECS[i], 1'b0);
    // R11: request raised mid-transfer with other fields
    run_vec('{1'b1, 1'b0, 1'b0, 5'd3, 5'h04, 16'h0000, 16'h0000, 16'h2222, 1'b0}, 1'b1);
    run_vec('{1'b0, 1'b1, 1'b0, 5'd4, 5'h05, 16'h00AA, 16'h1357, 16'h0000, 1'b0}, 1'b1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule